// File: doc/BRIEF.md
# Gamepad Parallel-to-Serial Button Reporter

This block is the logic inside a game controller. It takes eight button levels and sends them to a host console one bit at a time. The host drives two lines. The first is a latch line. While it is high, the register keeps capturing the live buttons, so the data line keeps showing the first button. The second is a pad clock line that rests high and dips low once for each host read. After the latch falls, each rising edge of the pad clock exposes the next button.

The data line is driven at wire level. A pressed button pulls the line low and a released button leaves it high, because the host inverts what it receives. After the eighth bit, a fixed tail level fills the register. By default this tail is wire-low, so the host reads 1 for every extra read.

A parameter builds a reduced pad that has no Select and no Start. In that variant both of those positions always report released.

All inputs are assumed to be synchronous to `clk`. The block samples the pad clock line with the system clock and detects its rising edges itself.

Top module: `gamepad_serializer`

## Requirements
- R1: While reset is asserted, and after it is released, the register holds all wire-high (nothing pressed), so `sdata_o` is 1.
- R2: On every system clock edge at which `latch_i` is high, the register reloads from `btn_i`. `sdata_o` then shows the first button (A, `btn_i[0]`) one cycle later.
- R3: A pad clock rising edge seen in a cycle where `latch_i` is high has no effect. The load wins, and the first bit after the latch falls is A of the last latched buttons.
- R4: With `latch_i` low, the contents hold while no rising edge is seen on `pclk_i`. Each rising edge, detected one system clock after `pclk_i` goes high, advances the register by exactly one bit.
- R5: Bits leave in the fixed order `btn_i[0]` to `btn_i[7]`, which stand for A, B, Select, Start, Up, Down, Left, Right.
- R6: On the wire a pressed button (`btn_i` bit = 1) gives `sdata_o` = 0, and a released button gives `sdata_o` = 1.
- R7: After eight advances, every further bit is the tail level `TAIL_WIRE`, which is 0 by default (the host reads 1).
- R8: With `OMIT_SEL_START` = 1, positions 2 (Select) and 3 (Start) always shift out as 1 (released), whatever `btn_i[3:2]` is.
- R9: One extra pad clock rising edge deletes exactly one bit from the sequence. The tail then appears one read early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_i | input | 1 | Host latch line; high = keep reloading |
| pclk_i | input | 1 | Host pad clock line; idles high, a rising edge advances one bit |
| btn_i | input | 8 | Debounced button levels, 1 = pressed, bit 0 = A through bit 7 = Right |
| sdata_o | output | 1 | Serial data at wire level, 0 = pressed |

## Verification
The bench places a pad clock rising edge in the same cycle as the last latched cycle. A design that lets the shift beat the load would present B where A belongs. It holds the pad clock still for several cycles after the latch falls, which exposes a register that drifts without an edge. It reads past the eighth bit to catch a wrong tail level. It injects a double pulse, which must remove exactly one bit, so a design that skips two bits or ignores the glitch reads a shifted sequence. A second instance built without Select and Start is driven with those buttons pressed, and it must still report them released.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int GP_BTN_N = 8;

  typedef enum int {
    GP_A      = 0,
    GP_B      = 1,
    GP_SELECT = 2,
    GP_START  = 3,
    GP_UP     = 4,
    GP_DOWN   = 5,
    GP_LEFT   = 6,
    GP_RIGHT  = 7
  } gp_btn_e;

  // Wire level of a released button
  localparam logic GP_RELEASED_WIRE = 1'b1;
endpackage

// File: rtl/gp_edge_detect.sv
module gp_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic rise_o
);
  logic line_q;
  logic line_d;

  always_comb begin
    line_d = line_i;
  end

  // Line idles high, so reset to high: no false edge at release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
    end else begin
      line_q <= line_d;
    end
  end

  assign rise_o = line_i & ~line_q;

  // R4: one rising edge of the line gives exactly one advance pulse
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/gp_load_mask.sv
module gp_load_mask #(
  parameter int BTN_N          = gp_pkg::GP_BTN_N,
  parameter bit OMIT_SEL_START = 1'b0
) (
  input  logic [BTN_N-1:0] btn_i,
  output logic [BTN_N-1:0] wire_o
);
  localparam int SEL_POS   = int'(gp_pkg::GP_SELECT);
  localparam int START_POS = int'(gp_pkg::GP_START);

  for (genvar i = 0; i < BTN_N; i++) begin : g_pos
    if (OMIT_SEL_START && (i == SEL_POS || i == START_POS)) begin : g_absent
      assign wire_o[i] = gp_pkg::GP_RELEASED_WIRE;
    end else begin : g_present
      // pressed (1) pulls the wire low
      assign wire_o[i] = ~btn_i[i];
    end
  end
endmodule

// File: rtl/gp_shift_reg.sv
module gp_shift_reg #(
  parameter int   BTN_N     = gp_pkg::GP_BTN_N,
  parameter logic TAIL_WIRE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [BTN_N-1:0] par_i,
  output logic             ser_o
);
  logic [BTN_N-1:0] sh_q;
  logic [BTN_N-1:0] sh_d;
  logic             sh_en;

  // Load has priority over shift
  always_comb begin
    sh_en = load_i | shift_i;
    sh_d  = sh_q;
    if (load_i) begin
      sh_d = par_i;
    end else if (shift_i) begin
      sh_d = {TAIL_WIRE, sh_q[BTN_N-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  assign ser_o = sh_q[0];

  // R2, R3: a load cycle captures the parallel word, shift or not
  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> sh_q == $past(par_i));
  // R4: no load and no edge leaves the contents alone
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(sh_q));
  // R7: each advance moves one place and fills with the tail level
  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && shift_i) |=> (sh_q[BTN_N-2:0] == $past(sh_q[BTN_N-1:1]))
                             && (sh_q[BTN_N-1] == TAIL_WIRE));
endmodule

// File: rtl/gamepad_serializer.sv
module gamepad_serializer #(
  parameter int   BTN_N          = gp_pkg::GP_BTN_N,
  parameter bit   OMIT_SEL_START = 1'b0,
  parameter logic TAIL_WIRE      = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_i,
  input  logic             pclk_i,
  input  logic [BTN_N-1:0] btn_i,
  output logic             sdata_o
);
  logic             rise;
  logic [BTN_N-1:0] par_wire;

  gp_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (pclk_i),
    .rise_o (rise)
  );

  gp_load_mask #(
    .BTN_N          (BTN_N),
    .OMIT_SEL_START (OMIT_SEL_START)
  ) u_mask (
    .btn_i  (btn_i),
    .wire_o (par_wire)
  );

  gp_shift_reg #(
    .BTN_N     (BTN_N),
    .TAIL_WIRE (TAIL_WIRE)
  ) u_sh (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (latch_i),
    .shift_i (rise),
    .par_i   (par_wire),
    .ser_o   (sdata_o)
  );

  // R6: while latched, the line shows button A inverted a cycle later
  a_r6_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    latch_i |=> sdata_o == !$past(btn_i[0]));
endmodule

// File: tb/test_gamepad_serializer.sv
module test_gamepad_serializer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       latch = 1'b0;
  logic       pclk = 1'b1;
  logic [7:0] btn = 8'h00;
  logic       sd_full;
  logic       sd_red;

  int n_checks = 0;
  int n_fail   = 0;

  logic  exp_full_q[$];
  logic  exp_red_q[$];
  string req_q[$];
  event  mon_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamepad_serializer i_gamepad_serializer (
    .clk(clk), .rst_n(rst_n), .latch_i(latch), .pclk_i(pclk),
    .btn_i(btn), .sdata_o(sd_full));

  gamepad_serializer #(.OMIT_SEL_START(1'b1)) i_gamepad_serializer_nss (
    .clk(clk), .rst_n(rst_n), .latch_i(latch), .pclk_i(pclk),
    .btn_i(btn), .sdata_o(sd_red));

  // Monitor: pops expectations and compares at the sample point
  initial begin
    forever begin
      @(mon_ev);
      while (exp_full_q.size() > 0) begin
        automatic logic  ef = exp_full_q.pop_front();
        automatic logic  er = exp_red_q.pop_front();
        automatic string rq = req_q.pop_front();
        n_checks += 2;
        if (sd_full !== ef) begin
          n_fail++;
          $display("FAIL %s full pad: got %b expected %b", rq, sd_full, ef);
        end
        if (sd_red !== er) begin
          n_fail++;
          $display("FAIL %s reduced pad: got %b expected %b", rq, sd_red, er);
        end
      end
    end
  end

  task automatic expect_now(input logic ef, input logic er, input string rq);
    exp_full_q.push_back(ef);
    exp_red_q.push_back(er);
    req_q.push_back(rq);
    -> mon_ev;
    #1;
  endtask

  task automatic pulse_pclk();
    @(negedge clk) pclk = 1'b0;
    @(negedge clk) pclk = 1'b1;
    @(negedge clk);
  endtask

  // Driver: latch a word, read 10 bits, optional extra edge before read g
  task automatic frame(input logic [7:0] b, input int g);
    logic [9:0] wf;
    logic [9:0] wr;
    int p;
    for (int i = 0; i < 10; i++) begin
      wf[i] = (i < 8) ? ~b[i] : 1'b0;
      wr[i] = (i == 2 || i == 3) ? 1'b1 : wf[i];
    end
    // R3: stale buttons first, then a pad clock edge in the last latch cycle
    @(negedge clk) begin latch = 1'b1; btn = ~b; pclk = 1'b0; end
    @(negedge clk) btn = b;
    @(negedge clk) pclk = 1'b1;
    @(negedge clk) latch = 1'b0;
    expect_now(wf[0], wr[0], "R3");
    // R4: hold without edges
    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      expect_now(wf[0], wr[0], "R4");
    end
    btn = 8'h00;
    p = 0;
    for (int k = 0; k < 9; k++) begin
      pulse_pclk();
      p++;
      if (k == g) begin
        pulse_pclk();
        p++;
      end
      if (p > 9) break;
      if (g >= 0 && k >= g) expect_now(wf[p], wr[p], "R9");
      else if (p >= 8)      expect_now(wf[p], wr[p], "R7");
      else if (p == 2 || p == 3) expect_now(wf[p], wr[p], "R8");
      else                  expect_now(wf[p], wr[p], "R5");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    expect_now(1'b1, 1'b1, "R1");
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    expect_now(1'b1, 1'b1, "R1");
    // R2, R6: while latched, output tracks A inverted
    @(negedge clk) begin latch = 1'b1; btn = 8'h01; end
    @(negedge clk) expect_now(1'b0, 1'b0, "R2");
    btn = 8'h00;
    @(negedge clk) expect_now(1'b1, 1'b1, "R6");
    latch = 1'b0;
    frame(8'h00, -1);
    frame(8'hFF, -1);
    frame(8'hA5, -1);
    frame(8'h5A, -1);
    frame(8'h0C, -1);
    frame(8'h81, 2);
    frame(8'hFF, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule